// File: doc/BRIEF.md
# CAN Error Report Unit

This unit is the error-reporting corner of a CAN controller. The protocol engine hands it single-cycle event pulses: eight status events and seven protocol error types. Each status event sets a sticky bit in an eight-bit flag register. An eight-bit enable register masks the flags, and the masked flags are ORed into one summary status. A separate one-bit interrupt enable turns that summary into the error interrupt line.

A second register, the error-code store, records which protocol error types were seen. Its top bit selects the recording style. With the bit set, new error types are ORed into the stored bits. With the bit clear, the stored bits are replaced by the latest error. Software clears flags and codes by writing a byte with 0 in each position to drop and 1 in each position to keep.

All register access uses one plain write port: an enable, a two-bit select and a data byte. The port has no back-pressure, and a write takes effect on the clock edge where the enable is sampled high. The register contents are visible on dedicated output pins.

Top module: `can_err_report`

## Requirements
- R1: After reset, the flag, enable and code registers are all zero, the interrupt enable is off, and `err_stat_o` and `err_irq_o` are low.
- R2: A pulse on `evt_i[k]` sets `flag_o[k]` at the next clock edge. The bit meanings are: 7 bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error. Bit 0 also sets when any `code_evt_i` bit pulses.
- R3: A write with select 0 clears each flag bit whose data bit is 0 and leaves the flag bits whose data bit is 1 unchanged.
- R4: When an event pulse and a clearing write hit the same flag or code bit in the same cycle, the bit ends up set.
- R5: A write with select 1 loads the enable register directly. The enable register uses the same bit positions as the flag register. Enables only mask the summary and never stop a flag from latching.
- R6: `err_stat_o` is the OR over all bits of (flag AND enable). It stays high until every enabled flag is cleared or its enable is removed.
- R7: A write with select 3 stores only data bit 5 as the interrupt enable and ignores the other data bits. `err_irq_o` is `err_stat_o` AND that enable.
- R8: A pulse on `code_evt_i[k]` sets `code_o[k]`. The bit meanings are: 6 ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff.
- R9: When `code_o[7]` is 0, a cycle with any code pulse replaces `code_o[6:0]` with exactly that cycle's pulses.
- R10: When `code_o[7]` is 1, code pulses are ORed into `code_o[6:0]`.
- R11: A write with select 2 loads bit 7 from the data. In bits 6:0, a data 0 clears the bit and a data 1 keeps it.
- R12: While `wr_en_i` is low, no register changes except through event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Status event pulses, one per flag bit |
| code_evt_i | input | 7 | Protocol error type pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flags, 1 enables, 2 code store, 3 interrupt enable |
| wr_data_i | input | 8 | Write data byte |
| flag_o | output | 8 | Sticky flag register |
| flag_en_o | output | 8 | Flag enable register |
| code_o | output | 8 | Code store; bit 7 is the accumulate mode |
| err_stat_o | output | 1 | Summary of enabled flags |
| err_irq_o | output | 1 | Error interrupt |

## Verification
Every register sits directly on an output pin. A wrong flag, enable or code bit therefore shows at the pins one clock edge after the pulse or write that caused it. The summary and interrupt are combinational from those registers, so a masking fault appears in the same cycle as the register value that exposes it. The bench sweeps every enable value against several flag patterns, and tests each bit position for set, clear and the case where a set and a clear collide. Both code-store modes are exercised, which exposes any wrong bit within one cycle.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned ERR_FLAG_W = 8;
  localparam int unsigned ERR_CODE_W = 7;
  localparam int unsigned ERR_DATA_W = 8;
  localparam int unsigned ERR_IRQ_BIT = 5;

  typedef enum logic [1:0] {
    SEL_FLAGS   = 2'd0,
    SEL_FLAG_EN = 2'd1,
    SEL_CODES   = 2'd2,
    SEL_IRQ_EN  = 2'd3
  } err_sel_e;
endpackage

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                    q_o[k] <= 1'b0;
      else if (set_i[k])              q_o[k] <= 1'b1;  // set wins over clear
      else if (clr_we_i && !keep_i[k]) q_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/err_code_store.sv
module err_code_store #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         we_i,
  input  logic [W:0]   wdata_i,
  output logic [W-1:0] code_o,
  output logic         accum_o
);
  logic         any_evt;
  logic [W-1:0] kept;
  logic [W-1:0] code_d;

  assign any_evt = |evt_i;
  assign kept    = we_i ? (code_o & wdata_i[W-1:0]) : code_o;

  always_comb begin
    if (!any_evt)     code_d = kept;
    else if (accum_o) code_d = kept | evt_i;
    else              code_d = evt_i;   // latest error replaces history
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      code_o  <= '0;
      accum_o <= 1'b0;
    end else begin
      code_o <= code_d;
      if (we_i) accum_o <= wdata_i[W];
    end
  end
endmodule

// File: rtl/err_summary.sv
module err_summary #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] en_i,
  input  logic         irq_en_i,
  output logic         stat_o,
  output logic         irq_o
);
  assign stat_o = |(flag_i & en_i);
  assign irq_o  = stat_o & irq_en_i;
endmodule

// File: rtl/can_err_report.sv
module can_err_report
  import can_err_pkg::*;
#(
  parameter int unsigned FLAG_W  = ERR_FLAG_W,
  parameter int unsigned CODE_W  = ERR_CODE_W,
  parameter int unsigned DATA_W  = ERR_DATA_W,
  parameter int unsigned IRQ_BIT = ERR_IRQ_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic [CODE_W-1:0] code_evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic [FLAG_W-1:0] flag_en_o,
  output logic [CODE_W:0]   code_o,
  output logic              err_stat_o,
  output logic              err_irq_o
);
  localparam int unsigned CODE_BYTE_W = CODE_W + 1;

  logic              we_flags, we_en, we_codes, we_irq;
  logic [FLAG_W-1:0] flag_set;
  logic [CODE_W-1:0] code_bits;
  logic              accum_mode;
  logic              irq_en_q;

  assign we_flags = wr_en_i && (wr_sel_i == 2'(SEL_FLAGS));
  assign we_en    = wr_en_i && (wr_sel_i == 2'(SEL_FLAG_EN));
  assign we_codes = wr_en_i && (wr_sel_i == 2'(SEL_CODES));
  assign we_irq   = wr_en_i && (wr_sel_i == 2'(SEL_IRQ_EN));

  // bit 0 (bus error) also latches on any protocol error type
  assign flag_set = evt_i | FLAG_W'(|code_evt_i);

  err_sticky_bank #(.W(FLAG_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flag_set),
    .clr_we_i (we_flags),
    .keep_i   (wr_data_i[FLAG_W-1:0]),
    .q_o      (flag_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag_en_o <= '0;
      irq_en_q  <= 1'b0;
    end else begin
      if (we_en)  flag_en_o <= wr_data_i[FLAG_W-1:0];
      if (we_irq) irq_en_q  <= wr_data_i[IRQ_BIT];
    end
  end

  err_code_store #(.W(CODE_W)) u_codes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (code_evt_i),
    .we_i    (we_codes),
    .wdata_i (wr_data_i[CODE_BYTE_W-1:0]),
    .code_o  (code_bits),
    .accum_o (accum_mode)
  );

  assign code_o = {accum_mode, code_bits};

  err_summary #(.W(FLAG_W)) u_sum (
    .flag_i   (flag_o),
    .en_i     (flag_en_o),
    .irq_en_i (irq_en_q),
    .stat_o   (err_stat_o),
    .irq_o    (err_irq_o)
  );
endmodule

// File: rtl/can_err_report_chk.sv
module can_err_report_chk
  import can_err_pkg::*;
#(
  parameter int unsigned FLAG_W = ERR_FLAG_W,
  parameter int unsigned CODE_W = ERR_CODE_W,
  parameter int unsigned DATA_W = ERR_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] evt_i,
  input logic [CODE_W-1:0] code_evt_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [FLAG_W-1:0] flag_o,
  input logic [FLAG_W-1:0] flag_en_o,
  input logic [CODE_W:0]   code_o,
  input logic              err_stat_o,
  input logic              err_irq_o
);
  logic [FLAG_W-1:0] sv;
  assign sv = {evt_i[FLAG_W-1:1], evt_i[0] | (|code_evt_i)};

  for (genvar k = 0; k < FLAG_W; k++) begin : g_chk
    assert_flag_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sv[k] |=> flag_o[k]);
    assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'(SEL_FLAGS) && !wr_data_i[k] && !sv[k]) |=> !flag_o[k]);
    assert_flag_no_spont_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[k]) |-> $past(sv[k]));
  end

  assert_stat_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_stat_o) && !$past(wr_en_i)) |-> err_stat_o);
  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> err_stat_o);
  assert_code_replace_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_o[CODE_W] && |code_evt_i) |=> code_o[CODE_W-1:0] == $past(code_evt_i));
  assert_code_accum_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o[CODE_W] && |code_evt_i) |=>
      (code_o[CODE_W-1:0] & $past(code_evt_i)) == $past(code_evt_i));
  assert_mode_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 2'(SEL_CODES)) |=> code_o[CODE_W] == $past(code_o[CODE_W]));
  assert_en_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> flag_en_o == $past(flag_en_o));
endmodule

bind can_err_report can_err_report_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .code_evt_i (code_evt_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .flag_o     (flag_o),
  .flag_en_o  (flag_en_o),
  .code_o     (code_o),
  .err_stat_o (err_stat_o),
  .err_irq_o  (err_irq_o)
);

// File: tb/sim_can_err_report.sv
`timescale 1ns/1ps
module sim_can_err_report;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic [6:0] cevt = '0;
  logic       we = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wd = '0;
  logic [7:0] flag_o, flag_en_o, code_o;
  logic       err_stat_o, err_irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mflag = '0, men = '0, mcode = '0;
  logic       mier = 1'b0;

  always #2.5 clk = ~clk;

  can_err_report u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .code_evt_i(cevt),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wd),
    .flag_o(flag_o), .flag_en_o(flag_en_o), .code_o(code_o),
    .err_stat_o(err_stat_o), .err_irq_o(err_irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic st;
    st = |(mflag & men);
    chk(tag, "flags", flag_o, mflag);
    chk(tag, "enables", flag_en_o, men);
    chk(tag, "codes", code_o, mcode);
    chk(tag, "stat", {7'd0, err_stat_o}, {7'd0, st});
    chk(tag, "irq", {7'd0, err_irq_o}, {7'd0, st & mier});
  endtask

  // one clock: inputs driven at negedge, model advanced, outputs sampled at next negedge
  task automatic cyc(input logic [7:0] ev, input logic [6:0] cev, input logic w,
                     input logic [1:0] s, input logic [7:0] d, input string tag);
    logic [7:0] setv;
    logic [6:0] base;
    logic       mode_old;
    evt = ev; cevt = cev; we = w; sel = s; wd = d;
    @(posedge clk);
    setv = {ev[7:1], ev[0] | (|cev)};
    mflag = ((w && s == 2'd0) ? (mflag & d) : mflag) | setv;
    if (w && s == 2'd1) men = d;
    if (w && s == 2'd3) mier = d[5];
    mode_old = mcode[7];
    base = (w && s == 2'd2) ? (mcode[6:0] & d[6:0]) : mcode[6:0];
    if (|cev) base = mode_old ? (base | cev) : cev;
    mcode = {(w && s == 2'd2) ? d[7] : mode_old, base};
    @(negedge clk);
    evt = '0; cevt = '0; we = 1'b0; sel = '0; wd = '0;
    chk_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2 / R5: each flag latches with enables at zero; R3 clears it
    for (int k = 0; k < 8; k++) begin
      cyc(8'(1 << k), 7'd0, 1'b0, 2'd0, 8'h00, "R2");
      cyc(8'h00, 7'd0, 1'b1, 2'd0, ~8'(1 << k), "R3");
    end
    // R3: keep with ones, partial clear
    cyc(8'hFF, 7'd0, 1'b0, 2'd0, 8'h00, "R2");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'hA5, "R3");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'hFF, "R3");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'h00, "R3");

    // R8 / R9: replace mode, each code type one-hot
    for (int k = 0; k < 7; k++)
      cyc(8'h00, 7'(1 << k), 1'b0, 2'd0, 8'h00, "R8");
    cyc(8'h00, 7'h02, 1'b0, 2'd0, 8'h00, "R9");
    cyc(8'h00, 7'h10, 1'b0, 2'd0, 8'h00, "R9");
    cyc(8'h00, 7'h41, 1'b0, 2'd0, 8'h00, "R9");
    // R11: enter accumulate mode; bit 0 cleared, others kept
    cyc(8'h00, 7'd0, 1'b1, 2'd2, 8'hFE, "R11");
    for (int k = 0; k < 7; k++)
      cyc(8'h00, 7'(1 << k), 1'b0, 2'd0, 8'h00, "R10");
    cyc(8'h00, 7'd0, 1'b1, 2'd2, 8'hF7, "R11");
    cyc(8'h00, 7'd0, 1'b1, 2'd2, 8'h80, "R11");
    cyc(8'h00, 7'h24, 1'b0, 2'd0, 8'h00, "R10");
    cyc(8'h00, 7'h09, 1'b0, 2'd0, 8'h00, "R10");

    // R4: collision of set and clear, flags and codes (accumulate mode)
    for (int k = 0; k < 8; k++) begin
      cyc(8'(1 << k), 7'd0, 1'b1, 2'd0, 8'h00, "R4");
      cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'h00, "R3");
    end
    for (int k = 0; k < 7; k++)
      cyc(8'h00, 7'(1 << k), 1'b1, 2'd2, 8'h80, "R4");
    // R9 with collision: back to replace mode, then clear plus event
    cyc(8'h00, 7'd0, 1'b1, 2'd2, 8'h7F, "R11");
    cyc(8'h00, 7'h08, 1'b1, 2'd2, 8'h00, "R4");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'h00, "R3");

    // R6: sweep every enable value against several flag patterns
    cyc(8'h00, 7'd0, 1'b1, 2'd3, 8'h20, "R7");
    for (int p = 0; p < 5; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : (p == 3) ? 8'h5A : 8'hFF;
      cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'h00, "R3");
      cyc(pat, 7'd0, 1'b0, 2'd0, 8'h00, "R2");
      for (int e = 0; e < 256; e++)
        cyc(8'h00, 7'd0, 1'b1, 2'd1, 8'(e), "R6");
    end

    // R6 persistence until all enabled flags cleared
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'h00, "R3");
    cyc(8'h00, 7'd0, 1'b1, 2'd1, 8'h24, "R5");
    cyc(8'h24, 7'd0, 1'b0, 2'd0, 8'h00, "R6");
    cyc(8'h00, 7'd0, 1'b0, 2'd0, 8'h00, "R6");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'hFB, "R6");
    cyc(8'h00, 7'd0, 1'b1, 2'd0, 8'hDF, "R6");

    // R7: only data bit 5 matters for interrupt enable
    cyc(8'h20, 7'd0, 1'b0, 2'd0, 8'h00, "R7");
    cyc(8'h00, 7'd0, 1'b1, 2'd3, 8'hDF, "R7");
    cyc(8'h00, 7'd0, 1'b1, 2'd3, 8'h20, "R7");
    cyc(8'h00, 7'd0, 1'b1, 2'd3, 8'hFF, "R7");

    // R12: writes ignored without strobe
    for (int s = 0; s < 4; s++)
      cyc(8'h00, 7'd0, 1'b0, 2'(s), 8'h00, "R12");
    cyc(8'h00, 7'd0, 1'b0, 2'd1, 8'hFF, "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule